// File: doc/BRIEF.md
# Multi-CPU Interrupt Priority Arbiter

This block keeps an enable bit for each interrupt source and a pending bit for each pairing of source and CPU. On every clock it runs one arbitration per CPU. The arbitration looks for the most urgent interrupt that is both enabled and pending for that CPU. It then tests the winner against two limits held for that CPU: a priority mask and a running priority. From these results it drives a request line and reports a highest-pending ID for each CPU.

Priorities are 8-bit values, and a lower number means a more urgent interrupt. IDs below 32 read their priority from a bank that each CPU has for itself. IDs of 32 and above share one priority entry across all CPUs.

The acknowledge logic, the completion logic and the register front end live outside this block. They drive it through plain set and clear vectors and single-cycle write strobes.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After a synchronous reset, every CPU has `irq_o` low and a highest-pending ID of 1023. All enable, pending and priority state is zero, each priority mask is 0xF0 and each running priority is 0x100 (idle).
- R2: An interrupt takes part in a CPU's arbitration only if its enable bit is set and its pending bit for that CPU is set. The pending bit for CPU c and source i sits at bit c*NUM_SRC+i of `pend_set_i` and `pend_clr_i`.
- R3: The candidate with the numerically lowest priority wins. When priorities are equal, the lowest ID wins.
- R4: A priority write to an ID below 32 changes only the bank of the CPU given by `prio_cpu_i`. A write to an ID from 32 to NUM_SRC-1 changes the one entry that all CPUs use. A write to an ID of NUM_SRC or above has no effect.
- R5: The highest-pending ID of a CPU equals the winner only when the winner's priority is less than or equal to that CPU's priority mask. Otherwise it is 1023. A mask write stores `mask_val_i` for every CPU whose bit in `mask_we_i` is set.
- R6: `irq_o[c]` is high only when the winner is within the mask and its priority is strictly less than the running priority of CPU c. A running-priority write stores the 9-bit `run_val_i`, where 0x100 means idle.
- R7: While `dist_en_i` is low, or `cpu_en_i[c]` is low, CPU c reports 1023 and `irq_o[c]` stays low. The other CPUs are not affected.
- R8: If a set and a clear reach the same enable bit or the same pending bit in one cycle, the set wins.
- R9: An input sampled at clock edge N is captured into state at edge N and shows at the outputs after edge N+1. `hp_id_o` carries the 10-bit ID of CPU c in bits [c*10+9:c*10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en_i | input | 1 | Global forwarding enable |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable |
| en_set_i | input | NUM_SRC | Set enable bits |
| en_clr_i | input | NUM_SRC | Clear enable bits |
| pend_set_i | input | NUM_CPU*NUM_SRC | Set pending bits, CPU-major |
| pend_clr_i | input | NUM_CPU*NUM_SRC | Clear pending bits, CPU-major |
| prio_we_i | input | 1 | Priority write strobe |
| prio_cpu_i | input | CPU_W | CPU whose bank a write to an ID below 32 targets |
| prio_id_i | input | 10 | Interrupt ID written |
| prio_val_i | input | 8 | Priority value written |
| mask_we_i | input | NUM_CPU | Per-CPU mask write strobe |
| mask_val_i | input | 8 | Mask value |
| run_we_i | input | NUM_CPU | Per-CPU running-priority write strobe |
| run_val_i | input | 9 | Running priority value |
| irq_o | output | NUM_CPU | Per-CPU request line |
| hp_id_o | output | NUM_CPU*10 | Per-CPU highest-pending ID |

## Verification
The bench targets several boundary cases:
- A winner whose priority equals the mask. A design that used a strict compare would drop this winner and report 1023.
- A winner whose priority equals the running priority. A design that used a non-strict compare would raise a request that should be blocked.
- Ties between a banked ID and a shared ID. A design that scanned in the wrong order, or kept the later candidate, would report the higher ID.
- The same banked ID given different priorities on two CPUs. A design that did not bank these priorities would have both CPUs pick the same winner.
- A set and a clear arriving together, and the exact cycle in which a new pending bit reaches the outputs.

A long stretch of mixed traffic then compares every cycle against a behavioural model. The stimulus includes writes to IDs out of range and changes to the mask and running priority.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int ID_W       = 10;
    localparam int PRIO_W     = 8;
    localparam int RUN_W      = PRIO_W + 1;
    localparam int BANKED_IDS = 32;

    localparam logic [ID_W-1:0]   NONE_ID   = 10'd1023;
    localparam logic [RUN_W-1:0]  IDLE_RUN  = 9'h100;
    localparam logic [PRIO_W-1:0] MASK_INIT = 8'hF0;

    // Best candidate found while scanning one CPU's sources
    typedef struct packed {
        logic [RUN_W-1:0] prio;
        logic [ID_W-1:0]  id;
    } cand_t;

    // Result presented for one CPU
    typedef struct packed {
        logic            req;
        logic [ID_W-1:0] id;
    } cpu_out_t;

    function automatic logic [RUN_W-1:0] widen(input logic [PRIO_W-1:0] p);
        return {1'b0, p};
    endfunction

    // Apply the mask and running-priority limits to a scan result
    function automatic cpu_out_t resolve(input cand_t best,
                                         input logic [PRIO_W-1:0] mask,
                                         input logic [RUN_W-1:0] run,
                                         input logic gate_on);
        cpu_out_t r;
        r.req = 1'b0;
        r.id  = NONE_ID;
        if (gate_on && (best.prio <= widen(mask))) begin
            r.id  = best.id;
            r.req = (best.prio < run);
        end
        return r;
    endfunction

endpackage

// File: rtl/arb_src_state.sv
module arb_src_state
    import arb_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int PEND_W = NUM_SRC * NUM_CPU
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] en_set_i,
    input  logic [NUM_SRC-1:0] en_clr_i,
    input  logic [PEND_W-1:0]  pend_set_i,
    input  logic [PEND_W-1:0]  pend_clr_i,
    output logic [NUM_SRC-1:0] en_q,
    output logic [PEND_W-1:0]  pend_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= (en_q & ~en_clr_i) | en_set_i;
            pend_q <= (pend_q & ~pend_clr_i) | pend_set_i;
        end
    end

    // R8: a set landing with a clear leaves the bit set
    a_r8_en_set_wins: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((en_q & $past(en_set_i)) == $past(en_set_i)));
    a_r8_pend_set_wins: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend_q & $past(pend_set_i)) == $past(pend_set_i)));
    // R2: a clear without a set removes the bit
    a_r2_pend_clear: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend_q & $past(pend_clr_i & ~pend_set_i)) == '0));

endmodule

// File: rtl/arb_prio_store.sv
module arb_prio_store
    import arb_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int SH_N   = NUM_SRC - BANKED_IDS,
    localparam int SH_W   = (SH_N > 1) ? $clog2(SH_N) : 1,
    localparam int BK_W   = $clog2(BANKED_IDS),
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prio_we_i,
    input  logic [CPU_W-1:0]  prio_cpu_i,
    input  logic [ID_W-1:0]   prio_id_i,
    input  logic [PRIO_W-1:0] prio_val_i,
    output logic [PRIO_W-1:0] tab_o [NUM_CPU][NUM_SRC]
);

    logic [PRIO_W-1:0] bank_q   [NUM_CPU][BANKED_IDS];
    logic [PRIO_W-1:0] shared_q [SH_N];

    logic hit_bank, hit_shared;
    logic [BK_W-1:0] bk_idx;
    logic [SH_W-1:0] sh_idx;

    always_comb begin
        hit_bank   = prio_we_i && (prio_id_i < ID_W'(BANKED_IDS))
                     && (int'(prio_cpu_i) < NUM_CPU);
        hit_shared = prio_we_i && (prio_id_i >= ID_W'(BANKED_IDS))
                     && (prio_id_i < ID_W'(NUM_SRC));
        bk_idx     = prio_id_i[BK_W-1:0];
        sh_idx     = SH_W'(prio_id_i - ID_W'(BANKED_IDS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CPU; c++)
                for (int i = 0; i < BANKED_IDS; i++)
                    bank_q[c][i] <= '0;
            for (int j = 0; j < SH_N; j++)
                shared_q[j] <= '0;
        end else begin
            if (hit_bank)
                bank_q[prio_cpu_i][bk_idx] <= prio_val_i;
            if (hit_shared)
                shared_q[sh_idx] <= prio_val_i;
        end
    end

    // Per-CPU view: banked entries for low IDs, shared entries above
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            if (i < BANKED_IDS) begin : g_bank
                assign tab_o[c][i] = bank_q[c][i];
            end else begin : g_shared
                assign tab_o[c][i] = shared_q[i - BANKED_IDS];
            end
        end
    end

    // R4: banked write lands in the addressed CPU's view
    a_r4_bank_write: assert property (@(posedge clk) disable iff (rst)
        hit_bank |=> tab_o[$past(prio_cpu_i)][$past(prio_id_i[SRC_W-1:0])]
                     == $past(prio_val_i));
    // R4: shared write is seen by first and last CPU
    a_r4_shared_write: assert property (@(posedge clk) disable iff (rst)
        hit_shared |=>
            (tab_o[0][$past(prio_id_i[SRC_W-1:0])] == $past(prio_val_i)) &&
            (tab_o[NUM_CPU-1][$past(prio_id_i[SRC_W-1:0])] == $past(prio_val_i)));

endmodule

// File: rtl/arb_picker.sv
module arb_picker
    import arb_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [PRIO_W-1:0] prio_i [NUM_SRC],
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [RUN_W-1:0]  run_i,
    input  logic              on_i,
    output cpu_out_t          res_o
);

    cand_t best;

    // Ascending scan with strict compare: lowest ID keeps a tie
    always_comb begin
        best.prio = IDLE_RUN;
        best.id   = NONE_ID;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (en_i[i] && pend_i[i] && (widen(prio_i[i]) < best.prio)) begin
                best.prio = widen(prio_i[i]);
                best.id   = ID_W'(i);
            end
        end
        res_o = resolve(best, mask_i, run_i, on_i);
    end

    // R2: a reported winner is enabled and pending
    a_r2_winner_live: assert property (@(posedge clk) disable iff (rst)
        (res_o.id != NONE_ID) |->
            (en_i[res_o.id[SRC_W-1:0]] && pend_i[res_o.id[SRC_W-1:0]]));
    // R5: a reported winner sits within the mask
    a_r5_within_mask: assert property (@(posedge clk) disable iff (rst)
        (res_o.id != NONE_ID) |-> (prio_i[res_o.id[SRC_W-1:0]] <= mask_i));
    // R6: a request beats the running priority
    a_r6_beats_run: assert property (@(posedge clk) disable iff (rst)
        res_o.req |-> (widen(prio_i[res_o.id[SRC_W-1:0]]) < run_i));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int PEND_W = NUM_SRC * NUM_CPU
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dist_en_i,
    input  logic [NUM_CPU-1:0]      cpu_en_i,
    input  logic [NUM_SRC-1:0]      en_set_i,
    input  logic [NUM_SRC-1:0]      en_clr_i,
    input  logic [PEND_W-1:0]       pend_set_i,
    input  logic [PEND_W-1:0]       pend_clr_i,
    input  logic                    prio_we_i,
    input  logic [CPU_W-1:0]        prio_cpu_i,
    input  logic [ID_W-1:0]         prio_id_i,
    input  logic [PRIO_W-1:0]       prio_val_i,
    input  logic [NUM_CPU-1:0]      mask_we_i,
    input  logic [PRIO_W-1:0]       mask_val_i,
    input  logic [NUM_CPU-1:0]      run_we_i,
    input  logic [RUN_W-1:0]        run_val_i,
    output logic [NUM_CPU-1:0]      irq_o,
    output logic [NUM_CPU*ID_W-1:0] hp_id_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [PEND_W-1:0]  pend_q;
    logic [PRIO_W-1:0]  prio_tab [NUM_CPU][NUM_SRC];
    logic [PRIO_W-1:0]  mask_q   [NUM_CPU];
    logic [RUN_W-1:0]   run_q    [NUM_CPU];
    logic               dist_q;
    logic [NUM_CPU-1:0] cpu_en_q;
    cpu_out_t           pick     [NUM_CPU];
    cpu_out_t           out_q    [NUM_CPU];

    arb_src_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
        .clk        (clk),
        .rst        (rst),
        .en_set_i   (en_set_i),
        .en_clr_i   (en_clr_i),
        .pend_set_i (pend_set_i),
        .pend_clr_i (pend_clr_i),
        .en_q       (en_q),
        .pend_q     (pend_q)
    );

    arb_prio_store #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_prio (
        .clk        (clk),
        .rst        (rst),
        .prio_we_i  (prio_we_i),
        .prio_cpu_i (prio_cpu_i),
        .prio_id_i  (prio_id_i),
        .prio_val_i (prio_val_i),
        .tab_o      (prio_tab)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_q   <= 1'b0;
            cpu_en_q <= '0;
        end else begin
            dist_q   <= dist_en_i;
            cpu_en_q <= cpu_en_i;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[c] <= MASK_INIT;
                run_q[c]  <= IDLE_RUN;
                out_q[c]  <= '{req: 1'b0, id: NONE_ID};
            end else begin
                if (mask_we_i[c]) mask_q[c] <= mask_val_i;
                if (run_we_i[c])  run_q[c]  <= run_val_i;
                out_q[c] <= pick[c];
            end
        end

        arb_picker #(.NUM_SRC(NUM_SRC)) u_pick (
            .clk    (clk),
            .rst    (rst),
            .en_i   (en_q),
            .pend_i (pend_q[c*NUM_SRC +: NUM_SRC]),
            .prio_i (prio_tab[c]),
            .mask_i (mask_q[c]),
            .run_i  (run_q[c]),
            .on_i   (dist_q && cpu_en_q[c]),
            .res_o  (pick[c])
        );

        assign irq_o[c]                 = out_q[c].req;
        assign hp_id_o[c*ID_W +: ID_W]  = out_q[c].id;

        // R1: limits and outputs come out of reset at their idle values
        a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (mask_q[c] == MASK_INIT) && (run_q[c] == IDLE_RUN)
                           && !irq_o[c] && (hp_id_o[c*ID_W +: ID_W] == NONE_ID));
        // R7: a closed gate yields no request and no pending ID
        a_r7_gate_closed: assert property (@(posedge clk) disable iff (rst)
            (!dist_q || !cpu_en_q[c]) |=>
                (!irq_o[c] && (hp_id_o[c*ID_W +: ID_W] == NONE_ID)));
        // R6: a request always comes with a reported ID
        a_r6_req_has_id: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] |-> (hp_id_o[c*ID_W +: ID_W] != NONE_ID));
        // R9: outputs follow the picker one cycle later
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (out_q[c] == $past(pick[c])));
    end

endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    localparam int NSRC = 64;
    localparam int NCPU = 2;
    localparam int CLK_PERIOD = 10;
    localparam int NONE = 1023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dist_en_i = 1'b0;
    logic [NCPU-1:0] cpu_en_i = '0;
    logic [NSRC-1:0] en_set_i = '0, en_clr_i = '0;
    logic [NCPU*NSRC-1:0] pend_set_i = '0, pend_clr_i = '0;
    logic prio_we_i = 1'b0;
    logic [0:0] prio_cpu_i = '0;
    logic [9:0] prio_id_i = '0;
    logic [7:0] prio_val_i = '0;
    logic [NCPU-1:0] mask_we_i = '0;
    logic [7:0] mask_val_i = '0;
    logic [NCPU-1:0] run_we_i = '0;
    logic [8:0] run_val_i = '0;
    logic [NCPU-1:0] irq_o;
    logic [NCPU*10-1:0] hp_id_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) u_irq_prio_arbiter (
        .clk(clk), .rst(rst), .dist_en_i(dist_en_i), .cpu_en_i(cpu_en_i),
        .en_set_i(en_set_i), .en_clr_i(en_clr_i),
        .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i),
        .prio_we_i(prio_we_i), .prio_cpu_i(prio_cpu_i), .prio_id_i(prio_id_i),
        .prio_val_i(prio_val_i), .mask_we_i(mask_we_i), .mask_val_i(mask_val_i),
        .run_we_i(run_we_i), .run_val_i(run_val_i),
        .irq_o(irq_o), .hp_id_o(hp_id_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1 reset";

    // Behavioural reference state
    int m_en [NSRC];
    int m_pend [NCPU][NSRC];
    int m_bank [NCPU][32];
    int m_sh [NSRC];
    int m_mask [NCPU];
    int m_run [NCPU];
    int m_dist;
    int m_cpuen [NCPU];
    int exp_irq [NCPU];
    int exp_hp [NCPU];

    function automatic void model_eval(input int c, output int rq, output int id);
        int best, bid, p;
        rq = 0; id = NONE;
        if (m_dist == 0 || m_cpuen[c] == 0) return;
        best = 256; bid = NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (m_en[i] != 0 && m_pend[c][i] != 0) begin
                p = (i < 32) ? m_bank[c][i] : m_sh[i];
                if (p < best) begin best = p; bid = i; end
            end
        end
        if (best <= m_mask[c]) begin
            id = bid;
            rq = (best < m_run[c]) ? 1 : 0;
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++) begin
                m_en[i] = 0; m_sh[i] = 0;
                for (int c = 0; c < NCPU; c++) m_pend[c][i] = 0;
            end
            for (int c = 0; c < NCPU; c++) begin
                for (int i = 0; i < 32; i++) m_bank[c][i] = 0;
                m_mask[c] = 'hF0; m_run[c] = 'h100; m_cpuen[c] = 0;
                exp_irq[c] = 0; exp_hp[c] = NONE;
            end
            m_dist = 0;
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                int r, h;
                model_eval(c, r, h);
                exp_irq[c] = r; exp_hp[c] = h;
            end
            for (int i = 0; i < NSRC; i++) begin
                if (en_set_i[i]) m_en[i] = 1;
                else if (en_clr_i[i]) m_en[i] = 0;
                for (int c = 0; c < NCPU; c++) begin
                    if (pend_set_i[c*NSRC+i]) m_pend[c][i] = 1;
                    else if (pend_clr_i[c*NSRC+i]) m_pend[c][i] = 0;
                end
            end
            if (prio_we_i) begin
                if (prio_id_i < 32) m_bank[prio_cpu_i][prio_id_i] = prio_val_i;
                else if (prio_id_i < NSRC) m_sh[prio_id_i] = prio_val_i;
            end
            for (int c = 0; c < NCPU; c++) begin
                if (mask_we_i[c]) m_mask[c] = mask_val_i;
                if (run_we_i[c]) m_run[c] = run_val_i;
                m_cpuen[c] = cpu_en_i[c];
            end
            m_dist = dist_en_i;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int c = 0; c < NCPU; c++) begin
                n_cmp += 2;
                if (int'(irq_o[c]) != exp_irq[c]) begin
                    n_bad++;
                    $display("FAIL [%s] cpu%0d irq got %0d expected %0d", tag, c, irq_o[c], exp_irq[c]);
                end
                if (int'(hp_id_o[c*10 +: 10]) != exp_hp[c]) begin
                    n_bad++;
                    $display("FAIL [%s] cpu%0d id got %0d expected %0d", tag, c, hp_id_o[c*10 +: 10], exp_hp[c]);
                end
            end
        end
    end

    // Directed check against literal values
    task automatic expect_cpu(input int c, input int rq, input int id, input string req);
        n_cmp++;
        if (int'(irq_o[c]) != rq || int'(hp_id_o[c*10 +: 10]) != id) begin
            n_bad++;
            $display("FAIL [%s] cpu%0d got irq=%0d id=%0d expected irq=%0d id=%0d",
                     req, c, irq_o[c], hp_id_o[c*10 +: 10], rq, id);
        end
    endtask

    task automatic clear_pulses();
        en_set_i = '0; en_clr_i = '0; pend_set_i = '0; pend_clr_i = '0;
        prio_we_i = 1'b0; mask_we_i = '0; run_we_i = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic settle();
        tick(); @(negedge clk);
    endtask

    task automatic wr_prio(input int c, input int id, input int v);
        prio_we_i = 1'b1; prio_cpu_i = 1'(c); prio_id_i = 10'(id); prio_val_i = 8'(v);
        tick();
    endtask

    task automatic set_pend(input int c, input int id);
        pend_set_i[c*NSRC+id] = 1'b1; tick();
    endtask

    task automatic set_run(input int c, input int v);
        run_we_i[c] = 1'b1; run_val_i = 9'(v); tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset outputs
        expect_cpu(0, 0, NONE, "R1");
        expect_cpu(1, 0, NONE, "R1");
        dist_en_i = 1'b1; cpu_en_i = 2'b11;

        // R5 with R1 mask of 0xF0: priority equal to mask is accepted
        tag = "R5 mask boundary";
        wr_prio(0, 40, 'hF0);
        en_set_i[40] = 1'b1; tick();
        set_pend(0, 40);
        settle();
        expect_cpu(0, 1, 40, "R5");
        expect_cpu(1, 0, NONE, "R2");
        wr_prio(0, 40, 'hF1);
        settle();
        expect_cpu(0, 0, NONE, "R5");

        // R4: banked ID 5 differs per CPU, shared ID 40
        tag = "R4 banked versus shared";
        wr_prio(0, 40, 'h40);
        wr_prio(0, 5, 'h10);
        wr_prio(1, 5, 'h80);
        en_set_i[5] = 1'b1; tick();
        set_pend(0, 5); set_pend(1, 5); set_pend(1, 40);
        settle();
        expect_cpu(0, 1, 5, "R4");
        expect_cpu(1, 1, 40, "R4");

        // R3: three-way tie at 0x10 resolves to lowest ID
        tag = "R3 tie order";
        wr_prio(0, 41, 'h10);
        wr_prio(0, 3, 'h10);
        en_set_i[41] = 1'b1; en_set_i[3] = 1'b1; tick();
        set_pend(0, 41); set_pend(0, 3);
        settle();
        expect_cpu(0, 1, 3, "R3");

        // R6: running priority equal to winner blocks the request
        tag = "R6 running priority";
        set_run(0, 'h10);
        settle();
        expect_cpu(0, 0, 3, "R6");
        set_run(0, 'h11);
        settle();
        expect_cpu(0, 1, 3, "R6");
        set_run(0, 'h100);

        // R7: gates
        tag = "R7 gating";
        dist_en_i = 1'b0;
        settle();
        expect_cpu(0, 0, NONE, "R7");
        expect_cpu(1, 0, NONE, "R7");
        dist_en_i = 1'b1; cpu_en_i = 2'b01;
        settle();
        expect_cpu(0, 1, 3, "R7");
        expect_cpu(1, 0, NONE, "R7");
        cpu_en_i = 2'b11;

        // R8: set and clear together
        tag = "R8 set beats clear";
        en_set_i[3] = 1'b1; en_clr_i[3] = 1'b1; tick();
        settle();
        expect_cpu(0, 1, 3, "R8");
        pend_set_i[3] = 1'b1; pend_clr_i[3] = 1'b1; tick();
        settle();
        expect_cpu(0, 1, 3, "R8");
        pend_clr_i[3] = 1'b1; tick();
        settle();
        expect_cpu(0, 1, 5, "R8");

        // R9: latency of a new pending bit on cpu1
        tag = "R9 latency";
        wr_prio(1, 2, 'h00);
        en_set_i[2] = 1'b1; tick();
        settle();
        expect_cpu(1, 1, 40, "R9");
        set_pend(1, 2);
        expect_cpu(1, 1, 40, "R9");
        @(negedge clk);
        expect_cpu(1, 1, 2, "R9");

        // Mixed traffic compared against the model every cycle
        tag = "R2 R3 R4 R5 R6 mixed traffic";
        for (int k = 0; k < 4000; k++) begin
            en_set_i   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            en_clr_i   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            pend_set_i = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
                         & {$urandom, $urandom, $urandom, $urandom};
            pend_clr_i = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            prio_we_i  = ($urandom % 2) == 0;
            prio_cpu_i = 1'($urandom % 2);
            prio_id_i  = 10'($urandom % 70);
            prio_val_i = 8'(($urandom % 6) * 32);
            mask_we_i  = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
            mask_val_i = 8'($urandom);
            run_we_i   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            run_val_i  = 9'(32 << ($urandom % 4));
            dist_en_i  = ($urandom % 25) != 0;
            cpu_en_i   = (($urandom % 20) == 0) ? 2'($urandom) : 2'b11;
            @(negedge clk);
        end
        clear_pulses();
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL [watchdog] run did not finish got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule